// File: doc/BRIEF.md
# Processor Run/Halt Sequencer

This block holds the RUN flag of a small 12-bit processor and decides, once per memory cycle, whether another cycle follows or the machine stops. While a cycle is under way (RUN set, or a front-panel memory operation in progress), it forms a next-RUN value from a fixed set of stop conditions. That value is loaded when the third timing strobe (`tp3_i`) is seen. If RUN is still set when the fourth strobe (`tp4_i`) arrives, the block issues a one-cycle memory-start pulse, so the next cycle follows the current one. It also checks every memory write against a protected address window. A hit is flagged as an illegal reference, the write enable is withheld, and the machine halts.

The front-panel keys arrive as raw levels. All seven pass through a two-flop synchronizer. START and CONT, and the three panel memory keys (load-address, examine, deposit), are then debounced into single-cycle pulses. STOP and SINGLE STEP are used as synchronized levels. The memory-start pulse, the panel-operation code and the write enable are plain control outputs with no handshake. Each is valid in the cycle it is asserted.

Top module: `run_halt_seq`

## Requirements
- R1: RUN changes only at a clock edge where `tp3_i` is high during an active cycle (RUN set or a panel operation in progress), or where an accepted START/CONT sets it; a `tp3_i` strobe while the machine is idle leaves RUN clear.
- R2: One cycle after an edge where `tp4_i` is high and RUN is set, `mem_start_o` is high for exactly one cycle; with RUN clear at `tp4_i`, no pulse is issued.
- R3: RUN is cleared at `tp3_i` when `ir_i` holds the halt instruction: bits [11:9] = 7, bit 8 = 1, bit 0 = 0 and bit 1 = 1 (octal 7402 form); octal 7403 and 7002 do not halt.
- R4: While the STOP key is held, RUN is cleared at `tp3_i` only if `next_fetch_i` is 1, so the halt falls on an instruction boundary.
- R5: A load-address, examine or deposit key press while halted issues one `mem_start_o` pulse and sets `panel_op_o` (1 = load address, 2 = examine, 3 = deposit, 0 = none; on simultaneous presses load address wins over examine, and examine over deposit); the cycle ends at `tp3_i` with `panel_op_o` = 0 and RUN clear.
- R6: RUN is cleared at `tp3_i` when `ext_stop_i` is 1 or `pwr_ok_i` is 0.
- R7: While SINGLE STEP is held, exactly one memory cycle runs per START: RUN is cleared at the first `tp3_i`.
- R8: `illegal_ref_o` is 1 exactly when `wr_req_i` is 1 and `addr_i` lies in octal 7600..7677; an illegal reference clears RUN at `tp3_i`.
- R9: `wr_en_o` follows `wr_req_i` except on an illegal reference, where it stays 0.
- R10: A START or CONT press while halted sets RUN and issues exactly one `mem_start_o` pulse, whatever the press length; the same press while RUN is set has no effect.
- R11: After reset, RUN, `mem_start_o` and `panel_op_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tp3_i | input | 1 | Third timing strobe: RUN load point |
| tp4_i | input | 1 | Fourth timing strobe: next-cycle launch point |
| next_fetch_i | input | 1 | The next cycle would fetch a new instruction |
| ir_i | input | 12 | Instruction register |
| key_start_i | input | 1 | START key, raw level |
| key_cont_i | input | 1 | CONT key, raw level |
| key_stop_i | input | 1 | STOP key, raw level |
| key_sstep_i | input | 1 | SINGLE STEP key, raw level |
| key_ldad_i | input | 1 | Load-address key, raw level |
| key_exam_i | input | 1 | Examine key, raw level |
| key_dep_i | input | 1 | Deposit key, raw level |
| pwr_ok_i | input | 1 | Power good |
| ext_stop_i | input | 1 | External stop request |
| wr_req_i | input | 1 | Memory write requested this cycle |
| addr_i | input | 12 | Memory address |
| run_o | output | 1 | RUN state |
| mem_start_o | output | 1 | One-cycle memory-start pulse |
| panel_op_o | output | 2 | Panel operation in progress (0 none, 1 load addr, 2 examine, 3 deposit) |
| illegal_ref_o | output | 1 | Write to the protected window |
| wr_en_o | output | 1 | Memory write enable after protection |

## Verification
The next-RUN logic is tested with one stop condition at a time, and each test includes a near-miss that must not halt. The halt word is paired with the 7403 and 7002 encodings, which differ from it in bit 0 and bit 8. STOP is held both with and without the fetch boundary. The protected window is probed at 7600, 7677, 7577 and 7700, and also with a read to an address inside the window. These pairs show that the halt is caused by the correct condition and not by any active cycle. Key presses are held well past the debounce time, both while halted and while running. This separates the pulse shaping from the gating on RUN. A strobe sent while the machine is idle shows that only active cycles reload RUN.

// File: rtl/run_halt_pkg.sv
package run_halt_pkg;
  localparam int WORD_W = 12;

  localparam int K_STOP  = 0;
  localparam int K_SSTEP = 1;
  localparam int K_START = 2;
  localparam int K_CONT  = 3;
  localparam int K_LDAD  = 4;
  localparam int K_EXAM  = 5;
  localparam int K_DEP   = 6;
  localparam int N_KEYS  = 7;
  localparam int N_PULSE = N_KEYS - K_START;

  typedef enum logic [1:0] {
    PNL_NONE = 2'd0,
    PNL_LDAD = 2'd1,
    PNL_EXAM = 2'd2,
    PNL_DEP  = 2'd3
  } panel_op_e;

  function automatic logic is_halt_word(input logic [WORD_W-1:0] w);
    return (w[11:9] == 3'o7) && w[8] && !w[0] && w[1];
  endfunction
endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/key_pulse.sv
module key_pulse #(
  parameter int DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  localparam int CW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
  localparam logic [CW-1:0] CNT_TOP = CW'(DEB_CYC - 1);

  logic          steady;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steady  <= 1'b0;
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (lvl_i != steady) begin
        if (cnt == CNT_TOP) begin
          steady  <= lvl_i;
          cnt     <= '0;
          pulse_o <= lvl_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/protect_chk.sv
module protect_chk #(
  parameter int              AW       = 12,
  parameter logic [AW-1:0]   WIN_BASE = 12'o7600,
  parameter int              WIN_BITS = 6
) (
  input  logic          wr_req_i,
  input  logic [AW-1:0] addr_i,
  output logic          illegal_o,
  output logic          wr_en_o
);
  localparam logic [AW-WIN_BITS-1:0] WIN_TAG = WIN_BASE[AW-1:WIN_BITS];

  logic in_window;

  always_comb begin
    in_window = (addr_i[AW-1:WIN_BITS] == WIN_TAG);
    illegal_o = wr_req_i && in_window;
    wr_en_o   = wr_req_i && !in_window;
  end
endmodule

// File: rtl/run_next.sv
module run_next
  import run_halt_pkg::*;
(
  input  logic [WORD_W-1:0] ir_i,
  input  logic              stop_key_i,
  input  logic              sstep_key_i,
  input  logic              next_fetch_i,
  input  logic              panel_cyc_i,
  input  logic              ext_stop_i,
  input  logic              pwr_ok_i,
  input  logic              illegal_i,
  output logic              next_run_o
);
  logic step_or_bad;
  logic halt_any;

  always_comb begin
    step_or_bad = sstep_key_i || illegal_i;
    halt_any    = is_halt_word(ir_i)
                || (stop_key_i && next_fetch_i)
                || panel_cyc_i
                || ext_stop_i
                || !pwr_ok_i
                || step_or_bad;
    next_run_o  = !halt_any;
  end
endmodule

// File: rtl/run_halt_seq.sv
module run_halt_seq
  import run_halt_pkg::*;
#(
  parameter int DEB_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tp3_i,
  input  logic              tp4_i,
  input  logic              next_fetch_i,
  input  logic [WORD_W-1:0] ir_i,
  input  logic              key_start_i,
  input  logic              key_cont_i,
  input  logic              key_stop_i,
  input  logic              key_sstep_i,
  input  logic              key_ldad_i,
  input  logic              key_exam_i,
  input  logic              key_dep_i,
  input  logic              pwr_ok_i,
  input  logic              ext_stop_i,
  input  logic              wr_req_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              run_o,
  output logic              mem_start_o,
  output logic [1:0]        panel_op_o,
  output logic              illegal_ref_o,
  output logic              wr_en_o
);
  logic [N_KEYS-1:0]  keys_raw;
  logic [N_KEYS-1:0]  keys_s;
  logic [N_PULSE-1:0] kp;
  logic               next_run;
  logic               illegal;
  logic               run_q;
  logic               ms_q;
  panel_op_e          pnl_q;
  logic               cyc_active;
  logic               go_p;

  assign keys_raw[K_STOP]  = key_stop_i;
  assign keys_raw[K_SSTEP] = key_sstep_i;
  assign keys_raw[K_START] = key_start_i;
  assign keys_raw[K_CONT]  = key_cont_i;
  assign keys_raw[K_LDAD]  = key_ldad_i;
  assign keys_raw[K_EXAM]  = key_exam_i;
  assign keys_raw[K_DEP]   = key_dep_i;

  key_sync #(.W(N_KEYS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (keys_raw),
    .q_o   (keys_s)
  );

  for (genvar gi = 0; gi < N_PULSE; gi++) begin : g_pulse
    key_pulse #(.DEB_CYC(DEB_CYC)) u_kp (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (keys_s[gi + K_START]),
      .pulse_o (kp[gi])
    );
  end

  protect_chk #(.AW(WORD_W)) u_prot (
    .wr_req_i  (wr_req_i),
    .addr_i    (addr_i),
    .illegal_o (illegal),
    .wr_en_o   (wr_en_o)
  );

  run_next u_next (
    .ir_i         (ir_i),
    .stop_key_i   (keys_s[K_STOP]),
    .sstep_key_i  (keys_s[K_SSTEP]),
    .next_fetch_i (next_fetch_i),
    .panel_cyc_i  (pnl_q != PNL_NONE),
    .ext_stop_i   (ext_stop_i),
    .pwr_ok_i     (pwr_ok_i),
    .illegal_i    (illegal),
    .next_run_o   (next_run)
  );

  assign cyc_active = run_q || (pnl_q != PNL_NONE);
  assign go_p       = kp[K_START - K_START] || kp[K_CONT - K_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ms_q  <= 1'b0;
      pnl_q <= PNL_NONE;
    end else begin
      ms_q <= tp4_i && run_q;
      if (tp3_i && cyc_active) begin
        run_q <= next_run;
        pnl_q <= PNL_NONE;
      end else if (!cyc_active) begin
        if (go_p) begin
          run_q <= 1'b1;
          ms_q  <= 1'b1;
        end else if (kp[K_LDAD - K_START]) begin
          pnl_q <= PNL_LDAD;
          ms_q  <= 1'b1;
        end else if (kp[K_EXAM - K_START]) begin
          pnl_q <= PNL_EXAM;
          ms_q  <= 1'b1;
        end else if (kp[K_DEP - K_START]) begin
          pnl_q <= PNL_DEP;
          ms_q  <= 1'b1;
        end
      end
    end
  end

  assign run_o         = run_q;
  assign mem_start_o   = ms_q;
  assign panel_op_o    = pnl_q;
  assign illegal_ref_o = illegal;
endmodule

// File: rtl/run_halt_chk.sv
module run_halt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tp3_i,
  input logic        tp4_i,
  input logic        pwr_ok_i,
  input logic        ext_stop_i,
  input logic [11:0] ir_i,
  input logic        wr_req_i,
  input logic [11:0] addr_i,
  input logic        run_o,
  input logic        mem_start_o,
  input logic [1:0]  panel_op_o,
  input logic        illegal_ref_o,
  input logic        wr_en_o
);
  logic active;
  assign active = run_o || (panel_op_o != 2'd0);

  p_fall_at_tp3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> $past(tp3_i));

  p_rise_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> mem_start_o);

  p_start_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start_o |-> (($past(tp4_i) && $past(run_o)) || $rose(run_o)
                     || ($past(panel_op_o) == 2'd0 && panel_op_o != 2'd0)));

  p_halt_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tp3_i && active && ir_i[11:9] == 3'o7 && ir_i[8] && !ir_i[0] && ir_i[1])
    |=> !run_o);

  p_panel_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(panel_op_o) != 2'd0 && panel_op_o == 2'd0) |-> !run_o);

  p_power_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tp3_i && (!pwr_ok_i || ext_stop_i)) |=> !run_o);

  p_illegal_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tp3_i && illegal_ref_o) |=> !run_o);

  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ref_o |-> (wr_req_i && addr_i >= 12'o7600 && addr_i <= 12'o7677));

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_req_i && !illegal_ref_o));
endmodule

bind run_halt_seq run_halt_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tp3_i         (tp3_i),
  .tp4_i         (tp4_i),
  .pwr_ok_i      (pwr_ok_i),
  .ext_stop_i    (ext_stop_i),
  .ir_i          (ir_i),
  .wr_req_i      (wr_req_i),
  .addr_i        (addr_i),
  .run_o         (run_o),
  .mem_start_o   (mem_start_o),
  .panel_op_o    (panel_op_o),
  .illegal_ref_o (illegal_ref_o),
  .wr_en_o       (wr_en_o)
);

// File: tb/tb_run_halt_seq.sv
`timescale 1ns/1ps
module tb_run_halt_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tp3 = 1'b0, tp4 = 1'b0, next_fetch = 1'b0;
  logic [11:0] ir = 12'o0000;
  logic        k_start = 0, k_cont = 0, k_stop = 0, k_sstep = 0;
  logic        k_ldad = 0, k_exam = 0, k_dep = 0;
  logic        pwr_ok = 1'b1, ext_stop = 1'b0, wr_req = 1'b0;
  logic [11:0] addr = 12'o0000;
  logic        run, mem_start, illegal, wr_en;
  logic [1:0]  pnl;

  int checks = 0, fails = 0, ms_count = 0;
  bit done = 0;

  typedef struct { bit r; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  run_halt_seq dut (
    .clk(clk), .rst_n(rst_n), .tp3_i(tp3), .tp4_i(tp4),
    .next_fetch_i(next_fetch), .ir_i(ir),
    .key_start_i(k_start), .key_cont_i(k_cont), .key_stop_i(k_stop),
    .key_sstep_i(k_sstep), .key_ldad_i(k_ldad), .key_exam_i(k_exam),
    .key_dep_i(k_dep), .pwr_ok_i(pwr_ok), .ext_stop_i(ext_stop),
    .wr_req_i(wr_req), .addr_i(addr), .run_o(run),
    .mem_start_o(mem_start), .panel_op_o(pnl),
    .illegal_ref_o(illegal), .wr_en_o(wr_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per TP4 edge and compares RUN and MEM_START
  initial begin
    forever begin
      bit was_tp4;
      @(posedge clk);
      was_tp4 = tp4;
      #1;
      if (mem_start) ms_count++;
      if (was_tp4 && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " run"}, int'(run), int'(e.r));
        check({e.tag, " mem_start"}, int'(mem_start), int'(e.r));
      end
    end
  end

  task automatic cycle(input bit exp_run, input string tag);
    exp_t e;
    e.r = exp_run;
    e.tag = tag;
    @(negedge clk) tp3 = 1'b1;
    q.push_back(e);
    @(negedge clk) begin tp3 = 1'b0; tp4 = 1'b1; end
    @(negedge clk) tp4 = 1'b0;
    @(negedge clk);
  endtask

  task automatic press(ref logic key, output int pulses);
    int base;
    base = ms_count;
    @(negedge clk) key = 1'b1;
    repeat (16) @(negedge clk);
    key = 1'b0;
    repeat (16) @(negedge clk);
    pulses = ms_count - base;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check("R11 run", int'(run), 0);
    check("R11 mem_start", int'(mem_start), 0);
    check("R11 panel_op", int'(pnl), 0);
    rst_n = 1'b1;

    // R1: stray strobe while idle
    cycle(1'b0, "R1 idle strobe");

    press(k_start, n);
    check("R10 start pulses", n, 1);
    check("R10 start run", int'(run), 1);
    cycle(1'b1, "R2 plain cycle");
    cycle(1'b1, "R2 second cycle");

    ir = 12'o7402; cycle(1'b0, "R3 halt word");
    ir = 12'o0000;
    press(k_cont, n);
    check("R10 cont pulses", n, 1);
    ir = 12'o7403; cycle(1'b1, "R3 bit0 set");
    ir = 12'o7002; cycle(1'b1, "R3 group1");
    ir = 12'o0000;
    press(k_cont, n);
    check("R10 cont while running", n, 0);
    check("R10 run kept", int'(run), 1);

    k_stop = 1'b1; next_fetch = 1'b0; settle();
    cycle(1'b1, "R4 stop mid-instruction");
    next_fetch = 1'b1; cycle(1'b0, "R4 stop at fetch");
    k_stop = 1'b0; next_fetch = 1'b0;

    press(k_start, n);
    ext_stop = 1'b1; cycle(1'b0, "R6 ext stop"); ext_stop = 1'b0;
    press(k_start, n);
    pwr_ok = 1'b0; cycle(1'b0, "R6 power fail"); pwr_ok = 1'b1;

    k_sstep = 1'b1; settle();
    press(k_start, n);
    check("R7 step start", n, 1);
    cycle(1'b0, "R7 single step");
    k_sstep = 1'b0; settle();

    press(k_start, n);
    wr_req = 1'b1; addr = 12'o7650; #1;
    check("R8 illegal 7650", int'(illegal), 1);
    check("R9 wr blocked", int'(wr_en), 0);
    cycle(1'b0, "R8 illegal halt");
    addr = 12'o7600; #1; check("R8 illegal 7600", int'(illegal), 1);
    addr = 12'o7677; #1; check("R8 illegal 7677", int'(illegal), 1);
    addr = 12'o7577; #1; check("R8 legal 7577", int'(illegal), 0);
    check("R9 wr 7577", int'(wr_en), 1);
    addr = 12'o7700; #1; check("R8 legal 7700", int'(illegal), 0);
    check("R9 wr 7700", int'(wr_en), 1);
    press(k_start, n);
    cycle(1'b1, "R8 write 7700 runs");
    wr_req = 1'b0; addr = 12'o7650; #1;
    check("R8 read in window", int'(illegal), 0);
    check("R9 no req no wr", int'(wr_en), 0);
    cycle(1'b1, "R8 read runs");
    ir = 12'o7402; cycle(1'b0, "R3 halt again"); ir = 12'o0000;

    press(k_exam, n);
    check("R5 exam pulses", n, 1);
    check("R5 exam op", int'(pnl), 2);
    cycle(1'b0, "R5 exam cycle");
    check("R5 exam cleared", int'(pnl), 0);

    @(negedge clk) begin k_ldad = 1'b1; k_dep = 1'b1; end
    repeat (16) @(negedge clk);
    k_ldad = 1'b0; k_dep = 1'b0;
    repeat (16) @(negedge clk);
    check("R5 ldad priority", int'(pnl), 1);
    cycle(1'b0, "R5 ldad cycle");
    press(k_dep, n);
    check("R5 dep op", int'(pnl), 3);
    cycle(1'b0, "R5 dep cycle");
    check("R5 dep cleared", int'(pnl), 0);

    settle();
    check("R2 queue drained", q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule